// File: doc/BRIEF.md
# Two-Wire to JTAG Bridge

The bridge lets a host reach an on-chip TAP controller over only two pins: a clock that the host drives, and one shared data line. The host sends packets of two or four slots, one bit per slot. The bridge reads TDI and TMS out of each packet. In four-slot mode it also returns one TDO bit on the same line. It then drives TCK, TMS and TDI toward the TAP, and it collects the TAP's TDO for the next packet.

A packet does not act on the TAP when it arrives. It is held until the first slot of the following packet, and only then is it applied with a single TCK pulse. All logic runs on a fast system clock. The debug clock and data line are treated as inputs that are already synchronous to that clock. The debug clock must stay in each level for at least six system cycles. The data pad driver sits outside the block, so the line is split into an input, an output value and an output enable.

Top module: `twowire_jtag_bridge`

## Requirements
- R1: A synchronous reset leaves `dbg_dat_oe` at 0, `tap_tck_o` at 0, `tap_tms_o` at 1 and `tap_tdi_o` at 0. It clears the slot counter to slot 0, discards any held packet and sets the stored TDO bit to 0.
- R2: Data-line bits are taken only on a falling edge of `dbg_clk_i`. Slot 0 carries TDI and slot 1 carries TMS. Changes on `dbg_dat_i` at any other time have no effect.
- R3: A packet's TDI and TMS reach `tap_tdi_o` and `tap_tms_o` in the system cycle after the first falling edge of the next packet, and not earlier. In the following cycle `tap_tck_o` goes high for exactly one system cycle. There is exactly one pulse per packet.
- R4: With `four_phase_i` = 1 a packet has four slots: TDI, TMS, turnaround, TDO. `dbg_dat_oe` rises one system cycle after the falling edge that ends the turnaround slot. It falls one system cycle after the falling edge that ends the TDO slot, and it is 0 at every other time.
- R5: With `four_phase_i` = 0 a packet has two slots, TDI then TMS, and `dbg_dat_oe` is never asserted.
- R6: During the TDO slot, `dbg_dat_o` carries the `tap_tdo_i` value sampled three system cycles after the most recent TAP step. It carries 0 if no step has occurred since reset.
- R7: Consecutive packets are applied to the TAP once each and in arrival order, in either mode. A least-significant-bit-first register shift therefore reaches `tap_tdi_o` bit 0 first.
- R8: A reset asserted part-way through a packet realigns the framing, so the next falling edge after release is treated as slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| four_phase_i | input | 1 | Framing select: 1 = four slots, 0 = two slots |
| dbg_clk_i | input | 1 | Host debug clock |
| dbg_dat_i | input | 1 | Data line value from the pad |
| dbg_dat_o | output | 1 | Data line value to drive in the TDO slot |
| dbg_dat_oe | output | 1 | Data line output enable |
| tap_tck_o | output | 1 | TCK to the TAP controller |
| tap_tms_o | output | 1 | TMS to the TAP controller |
| tap_tdi_o | output | 1 | TDI to the TAP controller |
| tap_tdo_i | input | 1 | TDO from the TAP controller |

## Verification
The bench checks that TAP outputs do not move when a packet completes and change only at the next packet's first falling edge. A bridge that stepped the TAP at once would show the new TMS a whole packet too early and would give the wrong pulse count. The data line is flipped just after every falling edge, so a design that sampled on the wrong edge or read a level would pick up the inverted bit. The run mixes two-slot and four-slot packets to confirm that the returned TDO always belongs to the latest TAP step and that the enable never appears in two-slot mode. A reset in the middle of a packet is checked by watching for the enable in the third slot of the next packet; a counter that was not cleared would raise it one slot early.

// File: rtl/twowire_jtag_bridge.sv
module twowire_jtag_bridge (
  input  logic clk,
  input  logic rst,
  input  logic four_phase_i,
  input  logic dbg_clk_i,
  input  logic dbg_dat_i,
  output logic dbg_dat_o,
  output logic dbg_dat_oe,
  output logic tap_tck_o,
  output logic tap_tms_o,
  output logic tap_tdi_o,
  input  logic tap_tdo_i
);

  logic       clk_q;
  logic [1:0] slot;
  logic       tdi_cap, tms_cap, pend;
  logic [1:0] step;
  logic       tdo_ret;

  wire fall = clk_q & ~dbg_clk_i;
  wire last = four_phase_i ? (slot == 2'd3) : (slot == 2'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q      <= 1'b0;
      slot       <= 2'd0;
      tdi_cap    <= 1'b0;
      tms_cap    <= 1'b0;
      pend       <= 1'b0;
      step       <= 2'd0;
      tdo_ret    <= 1'b0;
      dbg_dat_o  <= 1'b0;
      dbg_dat_oe <= 1'b0;
      tap_tck_o  <= 1'b0;
      tap_tms_o  <= 1'b1;
      tap_tdi_o  <= 1'b0;
    end else begin
      clk_q <= dbg_clk_i;
      if (fall) begin
        slot <= last ? 2'd0 : slot + 2'd1;
        case (slot)
          2'd0: begin
            tdi_cap <= dbg_dat_i;
            if (pend) begin
              tap_tdi_o <= tdi_cap;
              tap_tms_o <= tms_cap;
              step      <= 2'd1;
              pend      <= 1'b0;
            end
          end
          2'd1: begin
            tms_cap <= dbg_dat_i;
            if (!four_phase_i) pend <= 1'b1;
          end
          2'd2: begin
            dbg_dat_oe <= 1'b1;
            dbg_dat_o  <= tdo_ret;
          end
          default: begin
            dbg_dat_oe <= 1'b0;
            dbg_dat_o  <= 1'b0;
            pend       <= 1'b1;
          end
        endcase
      end
      case (step)
        2'd1: begin tap_tck_o <= 1'b1; step <= 2'd2; end
        2'd2: begin tap_tck_o <= 1'b0; step <= 2'd3; end
        2'd3: begin tdo_ret <= tap_tdo_i; step <= 2'd0; end
        default: ;
      endcase
    end
  end

endmodule

module twowire_jtag_bridge_chk (
  input logic clk,
  input logic rst,
  input logic four_phase_i,
  input logic dbg_clk_i,
  input logic dbg_dat_oe,
  input logic tap_tck_o,
  input logic tap_tms_o,
  input logic tap_tdi_o
);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dbg_dat_oe && !tap_tck_o && tap_tms_o));

  assert_tck_single_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(tap_tck_o) |=> !tap_tck_o);

  assert_tap_stable_R3: assert property (@(posedge clk) disable iff (rst)
    tap_tck_o |-> ($stable(tap_tms_o) && $stable(tap_tdi_o)));

  assert_oe_rise_edge_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(dbg_dat_oe) |-> (!$past(dbg_clk_i) && $past(dbg_clk_i, 2)));

  assert_oe_fall_edge_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(dbg_dat_oe) |-> (!$past(dbg_clk_i) && $past(dbg_clk_i, 2)));

  assert_oe_mode_R5: assert property (@(posedge clk) disable iff (rst)
    dbg_dat_oe |-> four_phase_i);

endmodule

bind twowire_jtag_bridge twowire_jtag_bridge_chk u_chk (
  .clk(clk), .rst(rst), .four_phase_i(four_phase_i), .dbg_clk_i(dbg_clk_i),
  .dbg_dat_oe(dbg_dat_oe), .tap_tck_o(tap_tck_o), .tap_tms_o(tap_tms_o),
  .tap_tdi_o(tap_tdi_o)
);

// File: tb/twowire_jtag_bridge_tb.sv
module twowire_jtag_bridge_tb;

  localparam int H = 6;
  localparam int NV = 12;
  // {four_phase, tdi, tms, tap_tdo}; TDI column of the first five = 5'b10110 LSB first
  localparam logic [3:0] VEC [NV] = '{
    4'b1011, 4'b1100, 4'b1101, 4'b0001, 4'b0110, 4'b1000,
    4'b1111, 4'b0100, 4'b0011, 4'b1110, 4'b1001, 4'b0101
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic four_phase_i = 1'b1;
  logic dbg_clk_i = 1'b1;
  logic dbg_dat_i = 1'b0;
  logic tap_tdo_i = 1'b0;
  logic dbg_dat_o, dbg_dat_oe, tap_tck_o, tap_tms_o, tap_tdi_o;

  int checks = 0, errors = 0;
  int tck_cnt = 0, tck_hi = 0, oe_two = 0;
  bit done = 0;

  always #2 clk = ~clk;

  twowire_jtag_bridge u_dut (
    .clk(clk), .rst(rst), .four_phase_i(four_phase_i), .dbg_clk_i(dbg_clk_i),
    .dbg_dat_i(dbg_dat_i), .dbg_dat_o(dbg_dat_o), .dbg_dat_oe(dbg_dat_oe),
    .tap_tck_o(tap_tck_o), .tap_tms_o(tap_tms_o), .tap_tdi_o(tap_tdi_o),
    .tap_tdo_i(tap_tdo_i)
  );

  always @(posedge tap_tck_o) tck_cnt++;
  always @(negedge clk) begin
    if (tap_tck_o) tck_hi++;
    if (!four_phase_i && dbg_dat_oe) oe_two++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic slot(input logic b);
    dbg_dat_i = b;
    dbg_clk_i = 1'b1;
    repeat (H) @(negedge clk);
    dbg_clk_i = 1'b0;
    @(negedge clk);
    dbg_dat_i = ~b;
    repeat (H - 1) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 oe", dbg_dat_oe, 0);
    chk("R1 tck", tap_tck_o, 0);
    chk("R1 tms", tap_tms_o, 1);
    chk("R1 tdi", tap_tdi_o, 0);

    for (int i = 0; i < NV; i++) begin
      logic m, di, ms, dout;
      {m, di, ms, dout} = VEC[i];
      four_phase_i = m;
      tap_tdo_i = dout;
      if (i == 1) begin
        chk("R3 no step before next packet tck", tck_cnt, 0);
        chk("R3 no step before next packet tms", tap_tms_o, 1);
      end
      slot(di);
      if (i > 0) begin
        chk("R3 one pulse per packet", tck_cnt, i);
        chk("R7 tdi order", tap_tdi_o, VEC[i-1][2]);
        chk("R2 tms taken in slot 1", tap_tms_o, VEC[i-1][1]);
      end
      slot(ms);
      if (m) begin
        chk("R4 oe low before turnaround", dbg_dat_oe, 0);
        slot(1'b1);
        chk("R4 oe high in tdo slot", dbg_dat_oe, 1);
        chk("R6 returned tdo", dbg_dat_o, (i == 0) ? 0 : dout);
        slot(1'b0);
        chk("R4 oe released", dbg_dat_oe, 0);
      end
    end
    chk("R3 tck high one cycle per pulse", tck_hi, tck_cnt);
    chk("R5 oe never in two-slot mode", oe_two, 0);

    four_phase_i = 1'b1;
    slot(1'b1);
    chk("R7 last packet applied", tap_tdi_o, VEC[NV-1][2]);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 tms after reset", tap_tms_o, 1);
    chk("R1 oe after reset", dbg_dat_oe, 0);

    begin
      int base;
      base = tck_cnt;
      tap_tdo_i = 1'b1;
      slot(1'b0);
      chk("R1 held packet discarded", tck_cnt, base);
      slot(1'b0);
      chk("R8 realigned, no oe in slot 2", dbg_dat_oe, 0);
      slot(1'b1);
      chk("R8 oe in slot 3 after reset", dbg_dat_oe, 1);
      chk("R1 stored tdo cleared", dbg_dat_o, 0);
      slot(1'b0);
      chk("R4 oe released after reset packet", dbg_dat_oe, 0);
      slot(1'b1);
      chk("R3 post-reset packet applied", tck_cnt, base + 1);
      chk("R3 post-reset tms", tap_tms_o, 0);
      chk("R2 post-reset tdi", tap_tdi_o, 0);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule